// File: doc/BRIEF.md
# ADC Conversion Sequencing Controller

This block holds the digital timing and data handling for one successive-approximation ADC. Software writes a small set of configuration registers that choose the start source, the resolution, the data alignment, the active channel, a sampling-duration code for each channel and whether finished results raise a DMA request. A conversion starts on a rising edge of the external trigger or on a software start write, depending on the selected source. The block then holds the sample-and-hold strobe high for the selected sampling window. Next it steps through the conversion phase, taking one comparator decision per bit, most significant bit first. At the end it formats the result into a 16-bit data word.

All timing runs on `clk`, which is taken to run at twice the ADC clock rate. One `clk` period is therefore half an ADC cycle, and fractional durations such as 2.5 or 12.5 ADC cycles become whole counts. A conversion at resolution R takes the sampling window plus R + 0.5 ADC cycles, which is 2R + 1 clocks.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Control register (address 0) fields: bit 0 `src_sw`, bit 1 `left`, bit 2 `dma_en`, bits 4:3 `res`, bits 6:5 `ch`. Writing address 2 with data bit 0 set is a software start. With `src_sw`=1, `busy` is high right after the clock edge of that write. With `src_sw`=0, a rising edge on `ext_trig` sets `busy` after the third clock edge that samples it high. The source that is not selected has no effect.
- R2: Address 1 holds a 3-bit sample-time code per channel, with channel n at bits 3n+2:3n. Codes 0 to 7 select 2.5, 7.5, 13.5, 28.5, 41.5, 55.5, 71.5 and 239.5 ADC cycles. `sh_hold` stays high for exactly twice that many clocks, starting on the first busy cycle.
- R3: `res` is encoded as 0=12, 1=10, 2=8 and 3=6 bits. The conversion phase follows the sampling window directly and lasts 2R+1 clocks, so `busy` is high for the sampling count plus 2R+1 clocks. At 12 bits with code 0 this is 30 clocks, or 15 ADC cycles.
- R4: During conversion, `cmp_req` is high on R single-clock slots: the 2nd, 4th, and so on up to the 2R-th conversion clock. `cmp_bit` is captured at the end of each slot, and the first capture becomes the most significant result bit.
- R5: With `left`=0, the R-bit result is zero-extended into `dout`. At 12 bits the upper four bits are zero; at 6 bits the upper ten bits are zero.
- R6: With `left`=1, a 12-, 10- or 8-bit result occupies the top bits of `dout` with zeros below. A 6-bit result occupies bits 7:2, and all other bits are zero.
- R7: `dout` changes only in the cycle after the conversion ends, and `eoc` is high for exactly that one cycle.
- R8: A start request of either kind that arrives while `busy` is high is ignored. No new conversion follows it.
- R9: When `dma_en` is set at the end of a conversion, `dma_req` rises together with `eoc` and stays high until a clock edge that samples `dma_ack` high. With `dma_en` clear, `dma_req` never rises.
- R10: After reset, `busy`, `sh_hold`, `cmp_req`, `eoc` and `dma_req` are low, and `dout` and `conv_ch` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock at twice the ADC clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | 12 | Configuration write data |
| ext_trig | input | 1 | External trigger, asynchronous |
| cmp_bit | input | 1 | Comparator decision for the current bit |
| dma_ack | input | 1 | DMA acknowledge, clears the request |
| busy | output | 1 | A conversion is in progress |
| sh_hold | output | 1 | Sample-and-hold strobe, high while sampling |
| cmp_req | output | 1 | A comparator decision is captured this cycle |
| conv_ch | output | 2 | Channel of the current or last conversion |
| dout | output | 16 | Formatted conversion result |
| eoc | output | 1 | One-cycle end-of-conversion flag |
| dma_req | output | 1 | DMA request for the finished result |

## Verification
On every cycle, the assertions check the following: the sample strobe and the comparator slots occur only inside a busy period and never overlap; a new sampling window opens only from idle; the data word holds steady except on the single end-of-conversion cycle; and a DMA request rises only together with that flag while DMA is enabled. The exact window lengths for each sample code and resolution, the bit order of the captured result, the alignment layouts, the trigger synchronizer latency, and the rule that the unselected start source is ignored depend on configuration. Only the bench scenarios, compared cycle by cycle against the reference model, can show these.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int DW    = 16;
    localparam int MAXR  = 12;
    localparam int CNT_W = 9;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_CONV   = 2'd2
    } seq_st_e;

    typedef enum logic [1:0] {
        RES_12 = 2'd0,
        RES_10 = 2'd1,
        RES_8  = 2'd2,
        RES_6  = 2'd3
    } res_e;

    // sampling window in half ADC cycles
    function automatic logic [CNT_W-1:0] samp_halves(input logic [2:0] code);
        logic [CNT_W-1:0] h;
        case (code)
            3'd0:    h = CNT_W'(5);
            3'd1:    h = CNT_W'(15);
            3'd2:    h = CNT_W'(27);
            3'd3:    h = CNT_W'(57);
            3'd4:    h = CNT_W'(83);
            3'd5:    h = CNT_W'(111);
            3'd6:    h = CNT_W'(143);
            default: h = CNT_W'(479);
        endcase
        return h;
    endfunction

    function automatic int unsigned res_bits(input res_e r);
        case (r)
            RES_12:  return 12;
            RES_10:  return 10;
            RES_8:   return 8;
            default: return 6;
        endcase
    endfunction

    // conversion phase in half ADC cycles: R + 0.5 cycles
    function automatic logic [CNT_W-1:0] conv_halves(input res_e r);
        return CNT_W'(2 * res_bits(r) + 1);
    endfunction

endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 2,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int ST_W  = 3 * NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ST_W-1:0]   wdata,
    output logic              src_sw,
    output logic              left,
    output logic              dma_en,
    output res_e              res,
    output logic [CH_W-1:0]   ch,
    output logic [ST_W-1:0]   smpt,
    output logic              sw_start
);

    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_SMPT  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_START = ADDR_W'(2);

    typedef struct packed {
        logic            src_sw;
        logic            left;
        logic            dma_en;
        res_e            res;
        logic [CH_W-1:0] ch;
        logic [ST_W-1:0] smpt;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we && addr == A_CTRL) begin
            cfg_d.src_sw = wdata[0];
            cfg_d.left   = wdata[1];
            cfg_d.dma_en = wdata[2];
            cfg_d.res    = res_e'(wdata[4:3]);
            cfg_d.ch     = wdata[5 +: CH_W];
        end
        if (we && addr == A_SMPT) begin
            cfg_d.smpt = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign src_sw   = cfg_q.src_sw;
    assign left     = cfg_q.left;
    assign dma_en   = cfg_q.dma_en;
    assign res      = cfg_q.res;
    assign ch       = cfg_q.ch;
    assign smpt     = cfg_q.smpt;
    assign sw_start = we && (addr == A_START) && wdata[0];

endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_async,
    output logic rise
);

    localparam int SR_W = SYNC_STAGES + 1;

    logic [SR_W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[SR_W-2:0], trig_async};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    // edge seen on the synchronized level against its previous value
    assign rise = sr_q[SR_W-2] & ~sr_q[SR_W-1];

endmodule

// File: rtl/adc_res_fmt.sv
module adc_res_fmt
    import adc_seq_pkg::*;
(
    input  logic [MAXR-1:0] raw,
    input  res_e            res,
    input  logic            left,
    output logic [DW-1:0]   word
);

    always_comb begin
        case (res)
            RES_12:  word = left ? {raw[11:0], 4'b0} : {4'b0, raw[11:0]};
            RES_10:  word = left ? {raw[9:0], 6'b0}  : {6'b0, raw[9:0]};
            RES_8:   word = left ? {raw[7:0], 8'b0}  : {8'b0, raw[7:0]};
            default: word = left ? {8'b0, raw[5:0], 2'b0} : {10'b0, raw[5:0]};
        endcase
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 2,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int ST_W  = 3 * NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [ST_W-1:0]   cfg_wdata,
    input  logic              ext_trig,
    input  logic              cmp_bit,
    input  logic              dma_ack,
    output logic              busy,
    output logic              sh_hold,
    output logic              cmp_req,
    output logic [CH_W-1:0]   conv_ch,
    output logic [DW-1:0]     dout,
    output logic              eoc,
    output logic              dma_req
);

    logic            cfg_src_sw, cfg_left, cfg_dma_en, sw_start, trig_rise;
    res_e            cfg_res;
    logic [CH_W-1:0] cfg_ch;
    logic [ST_W-1:0] cfg_smpt;
    logic [2:0]      code_arr [NUM_CH];
    logic [DW-1:0]   fmt_word;
    logic            start;

    adc_seq_cfg #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .src_sw   (cfg_src_sw),
        .left     (cfg_left),
        .dma_en   (cfg_dma_en),
        .res      (cfg_res),
        .ch       (cfg_ch),
        .smpt     (cfg_smpt),
        .sw_start (sw_start)
    );

    adc_trig_edge #(.SYNC_STAGES(2)) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_async (ext_trig),
        .rise       (trig_rise)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_code
        assign code_arr[g] = cfg_smpt[3*g +: 3];
    end

    typedef struct packed {
        seq_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic [MAXR-1:0]  sar;
        res_e             res;
        logic             left;
        logic [CH_W-1:0]  ch;
        logic [DW-1:0]    dout;
        logic             eoc;
        logic             dma_req;
    } seq_t;

    seq_t s_d, s_q;

    adc_res_fmt u_fmt (
        .raw  (s_q.sar),
        .res  (s_q.res),
        .left (s_q.left),
        .word (fmt_word)
    );

    assign start = (s_q.st == ST_IDLE) && (cfg_src_sw ? sw_start : trig_rise);

    always_comb begin
        s_d     = s_q;
        s_d.eoc = 1'b0;
        if (s_q.dma_req && dma_ack) begin
            s_d.dma_req = 1'b0;
        end
        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st   = ST_SAMPLE;
                    s_d.cnt  = samp_halves(code_arr[cfg_ch]) - CNT_W'(1);
                    s_d.res  = cfg_res;
                    s_d.left = cfg_left;
                    s_d.ch   = cfg_ch;
                    s_d.sar  = '0;
                end
            end
            ST_SAMPLE: begin
                if (s_q.cnt == '0) begin
                    s_d.st  = ST_CONV;
                    s_d.cnt = conv_halves(s_q.res) - CNT_W'(1);
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            ST_CONV: begin
                if (s_q.cnt[0]) begin
                    s_d.sar = {s_q.sar[MAXR-2:0], cmp_bit};
                end
                if (s_q.cnt == '0) begin
                    s_d.st   = ST_IDLE;
                    s_d.dout = fmt_word;
                    s_d.eoc  = 1'b1;
                    if (cfg_dma_en) begin
                        s_d.dma_req = 1'b1;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = (s_q.st != ST_IDLE);
    assign sh_hold = (s_q.st == ST_SAMPLE);
    assign cmp_req = (s_q.st == ST_CONV) && s_q.cnt[0];
    assign conv_ch = s_q.ch;
    assign dout    = s_q.dout;
    assign eoc     = s_q.eoc;
    assign dma_req = s_q.dma_req;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        sh_hold,
    input logic        cmp_req,
    input logic [15:0] dout,
    input logic        eoc,
    input logic        dma_req,
    input logic        dma_en
);

    // R2
    sample_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_hold |-> busy);

    // R4
    cmp_slot_in_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_req |-> (busy && !sh_hold));

    // R3
    sample_then_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sh_hold) |-> busy);

    // R8
    start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sh_hold) |-> !$past(busy));

    // R7
    eoc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |=> !eoc);

    // R7
    eoc_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |-> (!busy && $past(busy)));

    // R7
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eoc |-> $stable(dout));

    // R9
    dma_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> (eoc && $past(dma_en)));

endmodule

bind adc_seq_ctrl adc_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .sh_hold (sh_hold),
    .cmp_req (cmp_req),
    .dout    (dout),
    .eoc     (eoc),
    .dma_req (dma_req),
    .dma_en  (cfg_dma_en)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [11:0] cfg_wdata = '0;
    logic        ext_trig = 1'b0;
    logic        cmp_bit = 1'b0;
    logic        dma_ack = 1'b0;
    logic        busy, sh_hold, cmp_req, eoc, dma_req;
    logic [1:0]  conv_ch;
    logic [15:0] dout;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    adc_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ext_trig(ext_trig), .cmp_bit(cmp_bit),
        .dma_ack(dma_ack), .busy(busy), .sh_hold(sh_hold), .cmp_req(cmp_req),
        .conv_ch(conv_ch), .dout(dout), .eoc(eoc), .dma_req(dma_req)
    );

    // ---------------- reference model ----------------
    int          samp_tab [8] = '{5, 15, 27, 57, 83, 111, 143, 479};
    bit          c_src, c_left, c_dma;
    int          c_res, c_ch;
    logic [11:0] c_smpt;
    logic [11:0] pat;

    bit          m_busy, m_left, t1, t2, t3;
    int          m_e, m_S, m_C, m_R, m_res, m_ch;
    logic [11:0] m_pat;
    logic [15:0] e_dout;
    bit          e_eoc, e_dma;

    function automatic int nbits(int r);
        return (r == 0) ? 12 : (r == 1) ? 10 : (r == 2) ? 8 : 6;
    endfunction

    function automatic logic [15:0] fmt(logic [11:0] p, int r, bit lf);
        int n = nbits(r);
        logic [15:0] v = 16'(p) & 16'((1 << n) - 1);
        if (!lf) return v;
        if (n == 6) return v << 2;
        return v << (16 - n);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            c_src = 0; c_left = 0; c_dma = 0; c_res = 0; c_ch = 0; c_smpt = '0;
            m_busy = 0; m_e = 0; m_S = 0; m_C = 0; m_R = 12; m_res = 0; m_ch = 0;
            m_left = 0; m_pat = '0; t1 = 0; t2 = 0; t3 = 0;
            e_dout = '0; e_eoc = 0; e_dma = 0;
        end else begin
            bit go;
            go = !m_busy && (c_src ? (cfg_we && cfg_addr == 2'd2 && cfg_wdata[0])
                                   : (t2 && !t3));
            t3 = t2; t2 = t1; t1 = ext_trig;
            e_eoc = 0;
            if (e_dma && dma_ack) e_dma = 0;
            if (m_busy) begin
                if (m_e == m_S + m_C - 1) begin
                    m_busy = 0;
                    e_dout = fmt(m_pat, m_res, m_left);
                    e_eoc = 1;
                    if (c_dma) e_dma = 1;
                end else begin
                    m_e++;
                end
            end else if (go) begin
                m_busy = 1; m_e = 0; m_res = c_res; m_R = nbits(c_res);
                m_S = samp_tab[(c_smpt >> (3 * c_ch)) & 12'h7];
                m_C = 2 * m_R + 1; m_left = c_left; m_ch = c_ch; m_pat = pat;
            end
            if (cfg_we && cfg_addr == 2'd0) begin
                c_src = cfg_wdata[0]; c_left = cfg_wdata[1]; c_dma = cfg_wdata[2];
                c_res = int'(cfg_wdata[4:3]); c_ch = int'(cfg_wdata[6:5]);
            end
            if (cfg_we && cfg_addr == 2'd1) c_smpt = cfg_wdata;
        end
    end

    function automatic bit in_slot();
        return m_busy && m_e >= m_S && (((m_e - m_S) % 2) == 1);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // per-cycle comparison, then comparator stub drive
    always @(negedge clk) begin
        if (cyc >= 1 && !finished) begin
            chk("R1 R3 R8", "busy", int'(busy), int'(m_busy));
            chk("R2", "sh_hold", int'(sh_hold), int'(m_busy && m_e < m_S));
            chk("R4", "cmp_req", int'(cmp_req), int'(in_slot()));
            chk("R5 R6", "dout", int'(dout), int'(e_dout));
            chk("R7", "eoc", int'(eoc), int'(e_eoc));
            chk("R9", "dma_req", int'(dma_req), int'(e_dma));
            chk("R10", "conv_ch", int'(conv_ch), m_ch);
        end
        if (in_slot()) cmp_bit = m_pat[m_R - 1 - (m_e - m_S - 1) / 2];
        else           cmp_bit = 1'b1;
    end

    // ---------------- stimulus ----------------
    task automatic wr(int a, int d);
        cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = 12'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic int ctrl(bit src, bit lf, bit dma, int res, int ch);
        return int'(src) | (int'(lf) << 1) | (int'(dma) << 2) | (res << 3) | (ch << 5);
    endfunction

    task automatic wait_eoc();
        for (int i = 0; i < 2000; i++) begin
            if (eoc) break;
            @(negedge clk);
        end
    endtask

    task automatic sw_conv(int ch, int code, int res, bit lf, bit dma, logic [11:0] p, string req);
        pat = p;
        wr(0, ctrl(1, lf, dma, res, ch));
        wr(1, code << (3 * ch));
        wr(2, 1);
        chk("R1", "busy after software start", int'(busy), 1);
        wait_eoc();
        chk(req, "formatted result", int'(dout), int'(fmt(p, res, lf)));
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset values
        chk("R10", "busy in reset", int'(busy), 0);
        chk("R10", "dout in reset", int'(dout), 0);
        chk("R10", "dma_req in reset", int'(dma_req), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: 12-bit code 0 total busy length 30
        begin
            int n;
            pat = 12'hA5C;
            wr(0, ctrl(1, 0, 0, 0, 0));
            wr(1, 0);
            wr(2, 1);
            n = 0;
            while (busy && n < 100) begin n++; @(negedge clk); end
            chk("R3", "busy clocks 12-bit code 0", n, 30);
            chk("R5", "12-bit right result", int'(dout), 16'h0A5C);
            @(negedge clk);
        end

        sw_conv(1, 1, 0, 1, 0, 12'hA5C, "R6");
        sw_conv(2, 2, 1, 0, 0, 12'h3FF, "R5");
        sw_conv(3, 3, 1, 1, 0, 12'h2B7, "R6");
        sw_conv(0, 4, 2, 0, 0, 12'h0C3, "R5");
        sw_conv(1, 5, 2, 1, 0, 12'h0A9, "R6");
        sw_conv(2, 6, 3, 0, 0, 12'hFFF, "R5");
        sw_conv(3, 7, 3, 1, 0, 12'h02D, "R6");
        sw_conv(0, 0, 3, 1, 0, 12'h03F, "R6");

        // R9: DMA request held until acknowledge
        sw_conv(1, 0, 0, 0, 1, 12'h123, "R5");
        chk("R9", "dma_req held", int'(dma_req), 1);
        repeat (3) @(negedge clk);
        chk("R9", "dma_req still held", int'(dma_req), 1);
        dma_ack = 1'b1; @(negedge clk); dma_ack = 1'b0;
        chk("R9", "dma_req cleared by ack", int'(dma_req), 0);
        sw_conv(1, 0, 0, 0, 0, 12'h456, "R5");
        chk("R9", "no dma_req when disabled", int'(dma_req), 0);

        // R1: external source, software start ignored
        pat = 12'h5A5;
        wr(0, ctrl(0, 0, 0, 0, 2));
        wr(1, 12'h000);
        wr(2, 1);
        repeat (3) @(negedge clk);
        chk("R1", "software start ignored with external source", int'(busy), 0);
        ext_trig = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "busy low before sync latency", int'(busy), 0);
        @(negedge clk);
        chk("R1", "busy after third sampling edge", int'(busy), 1);
        // R8: second edge during conversion ignored
        repeat (5) @(negedge clk);
        ext_trig = 1'b0;
        repeat (3) @(negedge clk);
        ext_trig = 1'b1;
        wait_eoc();
        chk("R1", "external-start result", int'(dout), 16'h05A5);
        repeat (5) @(negedge clk);
        chk("R8", "trigger during conversion ignored", int'(busy), 0);
        ext_trig = 1'b0;
        @(negedge clk);

        // R8: software start during busy ignored
        pat = 12'h0F0;
        wr(0, ctrl(1, 0, 0, 0, 0));
        wr(2, 1);
        repeat (4) @(negedge clk);
        wr(2, 1);
        wait_eoc();
        repeat (3) @(negedge clk);
        chk("R8", "software start during conversion ignored", int'(busy), 0);

        // R1: external edge ignored with software source
        ext_trig = 1'b1;
        repeat (6) @(negedge clk);
        chk("R1", "external edge ignored with software source", int'(busy), 0);
        ext_trig = 1'b0;
        repeat (2) @(negedge clk);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 100000 && !finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule